// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer with DMA Slot Insertion

This block times every memory access of a small 8-bit processor core. Time is divided into machine cycles of a fixed number of clock slots. At the start of each cycle the sequencer latches a 16-bit address and sends it over a half-width address bus, high byte first and then low byte. It also drives the read strobe or the write strobe in fixed slots of the cycle. An instruction takes one fetch cycle followed by one or two execute cycles. The decoder sets `long_op` to ask for the second execute cycle.

At the end of an instruction's last execute cycle, the sequencer samples two DMA request lines. If either is pending, it inserts DMA cycles before the next fetch. These cycles take their address from the register-file port that carries R0, and the block pulses `r0_inc` so the register file advances that pointer. Three control inputs also affect sequencing. `clear_req` alone holds the block at the start of a fetch. `wait_req` alone freezes it in place. Both together place it in a load mode, in which no fetches occur and each input-DMA request writes external data into memory.

Top module: `mcyc_sequencer`

## Requirements
- R1: One machine cycle lasts 8 clocks, with `slot` counting 0 to 7 and advancing once per clock while running. `cyc_kind` changes only when slot 7 wraps. The kind encoding is 0 idle, 1 fetch, 2 first execute, 3 second execute, 4 DMA input, 5 DMA output.
- R2: In slots 0 and 1 of a non-idle cycle, `hi_phase` is 1 and `abus` carries address bits 15:8. In slots 2 to 7, `abus` carries bits 7:0 and `hi_phase` is 0. `hi_phase` is always 0 in idle cycles. The address is latched on the edge that starts the cycle.
- R3: A fetch is followed by a first execute cycle. A second execute cycle follows only if `long_op` is 1 in slot 7 of the first execute cycle. Fetch cycles use `fetch_addr` and execute cycles use `exec_addr`, each sampled on the edge that starts the cycle.
- R4: Read cycles assert `mrd` in slots 2 to 6. Read cycles are fetch, execute with `exec_wr` at 0, and DMA output. Write cycles assert `mwr` in slots 5 and 6. Write cycles are execute with `exec_wr` at 1 (sampled at cycle start) and DMA input.
- R5: DMA requests are sampled in slot 7 of the last execute cycle or of a DMA cycle. A pending request inserts a DMA cycle before the next fetch, addressed by `r0_val`.
- R6: When both requests are pending, the input request wins.
- R7: `r0_inc` is 1 for exactly the clock of slot 7 of each DMA cycle in which the slot advances.
- R8: `mem_wdata` is captured at the end of slot 4 of a write cycle. The source is `ext_data` for DMA input and `core_wdata` for execute writes.
- R9: `wait_req` alone freezes the slot, cycle kind, address and strobes for any number of clocks.
- R10: `clear_req` alone forces slot 0 of a fetch cycle addressed by `fetch_addr` with both strobes low. Running resumes from slot 0 when it is released.
- R11: Asserting both `clear_req` and `wait_req` enters load mode at slot 0 of an idle cycle. In load mode no fetch cycle ever occurs. Each cycle boundary starts a DMA input cycle if `dma_in_req` is 1, and an idle cycle otherwise.
- R12: Synchronous `rst` gives slot 0 of a fetch cycle at address 0, with both strobes low and `mem_wdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_req | input | 1 | Hold at fetch start; with wait_req, load mode |
| wait_req | input | 1 | Freeze sequencer; with clear_req, load mode |
| dma_in_req | input | 1 | Request for an external-to-memory transfer |
| dma_out_req | input | 1 | Request for a memory-to-external transfer |
| long_op | input | 1 | Current instruction needs a second execute cycle |
| exec_wr | input | 1 | Execute cycle writes memory |
| fetch_addr | input | 16 | Program counter value from register file |
| exec_addr | input | 16 | Operand address for execute cycles |
| r0_val | input | 16 | DMA pointer (R0) from register file |
| ext_data | input | 8 | External data for DMA input |
| core_wdata | input | 8 | Core data for execute writes |
| abus | output | 8 | Multiplexed address byte |
| hi_phase | output | 1 | abus carries the high address byte |
| mrd | output | 1 | Memory read strobe |
| mwr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Data presented for memory writes |
| r0_inc | output | 1 | Increment R0 this clock |
| slot | output | 3 | Clock slot within machine cycle |
| cyc_kind | output | 3 | Current machine cycle kind |

## Verification
The sequencer is run with short and long instructions, with execute reads and writes, and with moving fetch and operand addresses. These patterns separate two-cycle from three-cycle sequencing and catch addresses that are latched at the wrong edge. Lone output requests, then both requests together, show that DMA cycles are inserted only at instruction boundaries and that input wins. Wait, clear and load-mode episodes begin in the middle of a cycle. They show freezing, restarting at fetch, and the absence of fetches while data is written under R0. A behavioural model compares every output on every clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    CK_IDLE    = 3'd0,
    CK_FETCH   = 3'd1,
    CK_EXEC1   = 3'd2,
    CK_EXEC2   = 3'd3,
    CK_DMA_IN  = 3'd4,
    CK_DMA_OUT = 3'd5
  } cyc_kind_e;

  function automatic logic kind_is_dma(cyc_kind_e k);
    return (k == CK_DMA_IN) || (k == CK_DMA_OUT);
  endfunction
endpackage

// File: rtl/mcs_slot_ctr.sv
module mcs_slot_ctr #(
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic              last
);
  assign last = (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) slot <= '0;
    else if (adv)       slot <= last ? '0 : slot + 1'b1;
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart && !last) |=> slot == $past(slot) + 1'b1); // R1
  AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(slot)); // R9
endmodule

// File: rtl/mcs_cycle_fsm.sv
module mcs_cycle_fsm
  import mcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enter_load,
  input  logic      force_fetch,
  input  logic      load_level,
  input  logic      adv,
  input  logic      last,
  input  logic      long_op,
  input  logic      dma_in_req,
  input  logic      dma_out_req,
  output cyc_kind_e kind,
  output cyc_kind_e next_kind,
  output logic      load_q,
  output logic      kind_step
);
  cyc_kind_e after_instr;

  assign kind_step = adv && last;

  always_comb begin
    if (dma_in_req)       after_instr = CK_DMA_IN;
    else if (dma_out_req) after_instr = CK_DMA_OUT;
    else                  after_instr = CK_FETCH;

    if (load_q) begin
      next_kind = dma_in_req ? CK_DMA_IN : CK_IDLE;
    end else begin
      case (kind)
        CK_FETCH: next_kind = CK_EXEC1;
        CK_EXEC1: next_kind = long_op ? CK_EXEC2 : after_instr;
        CK_IDLE:  next_kind = CK_FETCH;
        default:  next_kind = after_instr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind   <= CK_FETCH;
      load_q <= 1'b0;
    end else begin
      load_q <= load_level;
      if (enter_load)       kind <= CK_IDLE;
      else if (force_fetch) kind <= CK_FETCH;
      else if (kind_step)   kind <= next_kind;
    end
  end

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!adv && !enter_load && !force_fetch) |=> $stable(kind)); // R9
  AST_LOAD_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    load_q |-> kind != CK_FETCH); // R11
  AST_IN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (kind_step && !load_q && dma_in_req && kind inside {CK_EXEC2, CK_DMA_IN, CK_DMA_OUT})
      |=> kind == CK_DMA_IN); // R6
  AST_CLEAR_FETCH: assert property (@(posedge clk) disable iff (rst)
    force_fetch |=> kind == CK_FETCH); // R10
endmodule

// File: rtl/mcs_bus_drv.sv
module mcs_bus_drv
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BUS_W  = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot,
  input  cyc_kind_e         kind,
  input  cyc_kind_e         next_kind,
  input  logic              kind_step,
  input  logic              force_fetch,
  input  logic              enter_load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [ADDR_W-1:0] r0_val,
  input  logic              exec_wr,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [BUS_W-1:0]  abus,
  output logic              hi_phase,
  output logic              mrd,
  output logic              mwr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int HI_SLOTS = 2;
  localparam int RD_FIRST = 2;
  localparam int RD_LAST  = SLOTS - 2;
  localparam int WR_FIRST = SLOTS - 3;
  localparam int WR_LAST  = SLOTS - 2;
  localparam int CAP_SLOT = SLOTS - 4;

  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic              wr_q, nxt_wr;
  logic              early;

  always_comb begin
    case (next_kind)
      CK_FETCH:           nxt_addr = fetch_addr;
      CK_EXEC1, CK_EXEC2: nxt_addr = exec_addr;
      default:            nxt_addr = r0_val;
    endcase
    nxt_wr = (next_kind == CK_DMA_IN) ||
             ((next_kind == CK_EXEC1 || next_kind == CK_EXEC2) && exec_wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      wr_q      <= 1'b0;
      mem_wdata <= '0;
    end else if (force_fetch) begin
      addr_q <= fetch_addr;
      wr_q   <= 1'b0;
    end else if (enter_load) begin
      addr_q <= r0_val;
      wr_q   <= 1'b0;
    end else if (kind_step) begin
      addr_q <= nxt_addr;
      wr_q   <= nxt_wr;
    end else if (adv && wr_q && slot == SLOT_W'(CAP_SLOT)) begin
      mem_wdata <= (kind == CK_DMA_IN) ? ext_data : core_wdata;
    end
  end

  assign early    = slot < SLOT_W'(HI_SLOTS);
  assign hi_phase = early && (kind != CK_IDLE);
  assign abus     = early ? addr_q[ADDR_W-1 -: BUS_W] : addr_q[BUS_W-1:0];
  assign mrd      = (kind != CK_IDLE) && !wr_q &&
                    slot >= SLOT_W'(RD_FIRST) && slot <= SLOT_W'(RD_LAST);
  assign mwr      = wr_q && slot >= SLOT_W'(WR_FIRST) && slot <= SLOT_W'(WR_LAST);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!kind_step && !force_fetch && !enter_load) |=> $stable(addr_q)); // R2
  AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    (mwr && $past(mwr)) |-> $stable(mem_wdata)); // R8
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BUS_W  = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_req,
  input  logic              wait_req,
  input  logic              dma_in_req,
  input  logic              dma_out_req,
  input  logic              long_op,
  input  logic              exec_wr,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [ADDR_W-1:0] r0_val,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [BUS_W-1:0]  abus,
  output logic              hi_phase,
  output logic              mrd,
  output logic              mwr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              r0_inc,
  output logic [SLOT_W-1:0] slot,
  output logic [2:0]        cyc_kind
);
  cyc_kind_e kind, next_kind;
  logic load_q, kind_step, last;
  logic load_level, enter_load, force_fetch, adv;

  assign load_level  = clear_req && wait_req;
  assign enter_load  = load_level && !load_q;
  assign force_fetch = clear_req && !wait_req;
  assign adv         = !rst && ((!clear_req && !wait_req) || (load_level && load_q));

  mcs_slot_ctr #(.SLOTS(SLOTS)) slot_i (
    .clk(clk), .rst(rst), .restart(enter_load || force_fetch),
    .adv(adv), .slot(slot), .last(last)
  );

  mcs_cycle_fsm fsm_i (
    .clk(clk), .rst(rst), .enter_load(enter_load), .force_fetch(force_fetch),
    .load_level(load_level), .adv(adv), .last(last), .long_op(long_op),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .kind(kind),
    .next_kind(next_kind), .load_q(load_q), .kind_step(kind_step)
  );

  mcs_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) bus_i (
    .clk(clk), .rst(rst), .slot(slot), .kind(kind), .next_kind(next_kind),
    .kind_step(kind_step), .force_fetch(force_fetch), .enter_load(enter_load),
    .adv(adv), .fetch_addr(fetch_addr), .exec_addr(exec_addr), .r0_val(r0_val),
    .exec_wr(exec_wr), .ext_data(ext_data), .core_wdata(core_wdata),
    .abus(abus), .hi_phase(hi_phase), .mrd(mrd), .mwr(mwr), .mem_wdata(mem_wdata)
  );

  assign r0_inc   = kind_step && kind_is_dma(kind);
  assign cyc_kind = kind;

  AST_R0_INC_DMA: assert property (@(posedge clk) disable iff (rst)
    r0_inc |-> (cyc_kind == 3'd4 || cyc_kind == 3'd5)); // R7
  AST_CLEAR_SLOT0: assert property (@(posedge clk) disable iff (rst)
    force_fetch |=> (slot == '0 && !mrd && !mwr)); // R10
endmodule

// File: tb/mcyc_sequencer_tb.sv
`timescale 1ns/100ps
module mcyc_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear_req = 0, wait_req = 0, dma_in_req = 0, dma_out_req = 0;
  logic long_op = 0, exec_wr = 0;
  logic [15:0] fetch_addr = 16'h1234, exec_addr = 16'hAB40, r0_val;
  logic [7:0]  ext_data = 8'h00, core_wdata = 8'h00;
  logic [7:0]  abus, mem_wdata;
  logic        hi_phase, mrd, mwr, r0_inc;
  logic [2:0]  slot, cyc_kind;

  always #2.5 clk = ~clk;

  mcyc_sequencer dut_i (
    .clk(clk), .rst(rst), .clear_req(clear_req), .wait_req(wait_req),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .long_op(long_op),
    .exec_wr(exec_wr), .fetch_addr(fetch_addr), .exec_addr(exec_addr),
    .r0_val(r0_val), .ext_data(ext_data), .core_wdata(core_wdata),
    .abus(abus), .hi_phase(hi_phase), .mrd(mrd), .mwr(mwr),
    .mem_wdata(mem_wdata), .r0_inc(r0_inc), .slot(slot), .cyc_kind(cyc_kind)
  );

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit chk_en = 0, in_load = 0;
  int fetch_in_load = 0, dut_incs = 0, mdl_incs = 0, dma_in_seen = 0;
  string phase = "R3";

  // behavioural model state
  int m_slot, m_kind, m_addr, m_wdata;
  bit m_load, m_wr;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_adv();
    return !rst && ((!clear_req && !wait_req) || (clear_req && wait_req && m_load));
  endfunction

  function automatic bit m_inc();
    return m_adv() && m_slot == 7 && (m_kind == 4 || m_kind == 5);
  endfunction

  always @(posedge clk) begin
    bit inc;
    int nk;
    inc = m_inc();
    if (rst) begin
      m_slot = 0; m_kind = 1; m_load = 0; m_addr = 0; m_wr = 0; m_wdata = 0;
      r0_val <= 16'h0400;
    end else begin
      if (clear_req && wait_req && !m_load) begin
        m_slot = 0; m_kind = 0; m_addr = r0_val; m_wr = 0;
      end else if (clear_req && !wait_req) begin
        m_slot = 0; m_kind = 1; m_addr = fetch_addr; m_wr = 0;
      end else if (m_adv()) begin
        if (m_slot == 4 && m_wr) m_wdata = (m_kind == 4) ? ext_data : core_wdata;
        if (m_slot == 7) begin
          if (m_load) nk = dma_in_req ? 4 : 0;
          else if (m_kind == 1) nk = 2;
          else if (m_kind == 0) nk = 1;
          else if (m_kind == 2 && long_op) nk = 3;
          else nk = dma_in_req ? 4 : (dma_out_req ? 5 : 1);
          m_kind = nk;
          m_addr = (nk == 1) ? fetch_addr : ((nk == 2 || nk == 3) ? exec_addr : r0_val);
          m_wr   = (nk == 4) || ((nk == 2 || nk == 3) && exec_wr);
          m_slot = 0;
        end else m_slot++;
      end
      m_load = clear_req && wait_req;
      if (inc) r0_val <= r0_val + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit e_early;
      e_early = m_slot < 2;
      chk("R1", "slot", slot, m_slot);
      chk(phase, "cyc_kind", cyc_kind, m_kind);
      chk("R2", "hi_phase", hi_phase, e_early && m_kind != 0);
      chk("R2", "abus", abus, e_early ? (m_addr >> 8) & 255 : m_addr & 255);
      chk("R4", "mrd", mrd, m_kind != 0 && !m_wr && m_slot >= 2 && m_slot <= 6);
      chk("R4", "mwr", mwr, m_wr && m_slot >= 5 && m_slot <= 6);
      chk("R8", "mem_wdata", mem_wdata, m_wdata);
      chk("R7", "r0_inc", r0_inc, m_inc());
      if (in_load && cyc_kind == 3'd1) fetch_in_load++;
      if (r0_inc) dut_incs++;
      if (m_inc()) mdl_incs++;
      if (in_load && mwr && slot == 3'd5) dma_in_seen++;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      chk("WD", "watchdog", 1, 0);
      finish_run();
    end
  end

  initial begin
    run(3);
    rst = 0;
    @(negedge clk);
    // R12: reset state seen one clock after release is slot 1 of fetch at 0
    chk("R12", "slot after reset", slot, 1);
    chk("R12", "kind after reset", cyc_kind, 1);
    chk("R12", "abus after reset", abus, 0);
    chk("R12", "wdata after reset", mem_wdata, 0);
    chk_en = 1; #1;
    phase = "R3";
    run(30); fetch_addr = 16'h5678; exec_addr = 16'h9ABC; run(30);
    long_op = 1; run(40);
    exec_wr = 1; core_wdata = 8'h5A; run(30); core_wdata = 8'hC3; run(24);
    long_op = 0; exec_wr = 0;
    phase = "R5";
    dma_out_req = 1; run(50); dma_out_req = 0; run(20);
    phase = "R6";
    dma_in_req = 1; dma_out_req = 1; ext_data = 8'h77; run(40);
    dma_in_req = 0; run(30); dma_out_req = 0; run(20);
    phase = "R9";
    run(3); wait_req = 1; run(37); wait_req = 0; run(20);
    phase = "R10";
    run(5); clear_req = 1; fetch_addr = 16'h0F0F; run(10); clear_req = 0; run(20);
    phase = "R11";
    run(3); clear_req = 1; wait_req = 1; in_load = 1;
    for (int i = 0; i < 6; i++) begin
      dma_in_req = i[0]; ext_data = 8'h10 + 8'(i); run(16);
    end
    dma_in_req = 1; run(30); dma_in_req = 0;
    in_load = 0; wait_req = 0; run(6); clear_req = 0; run(40);
    chk("R11", "fetch cycles in load mode", fetch_in_load, 0);
    chk("R11", "load writes seen", dma_in_seen > 3, 1);
    chk("R7", "r0_inc pulse count", dut_incs, mdl_incs);
    finish_run();
  end
endmodule